// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a six-bit record of why the device was last reset. Each reset source drives a one-cycle pulse into the block: the external reset pin, power-on, brown-out, watchdog, a software reset request and loss of regulator power-good. An external reset replaces the whole record with its own flag. Every other source adds its flag to whatever is already recorded, so software can see several causes that built up over successive resets.

The flops are cleared only by an always-on power-up initialiser (`por_n`). The system resets that the block reports therefore do not wipe the record. Software reads and writes the field through a simple 32-bit port. The port uses a 6-bit word address, and the register answers at word 0x17, which is byte offset 0x05C.

The port has two states. In `ST_IDLE` no read response is pending. A read strobe that hits the register takes the transition `IDLE_TO_RESP` into `ST_RESP`, and `bus_rvalid` is high in that state. From `ST_RESP`, a further hitting read keeps the port there (`RESP_HOLD`). Any other cycle takes the port back to idle (`RESP_TO_IDLE`). Without a hitting read, the port stays in idle (`IDLE_HOLD`).

Top module: `rstcause_reg`

## Requirements
- R1: The register responds only at word address 0x17 (byte offset 0x05C). A write to any other address leaves the record unchanged, and a read of any other address produces no `bus_rvalid`.
- R2: The bits of `cause_pulse` and of the record are mapped as follows: bit 0 external pin, bit 1 power-on, bit 2 brown-out, bit 3 watchdog, bit 4 software request, bit 5 regulator power-good loss.
- R3: An external pulse (bit 0) sets record bit 0 and clears bits 5:1 in the same update.
- R4: A pulse on bits 5:1 without bit 0 sets its own bit and keeps every bit already recorded.
- R5: A write to the register loads record bits 5:0 from `bus_wdata[5:0]`. Software can therefore clear or overwrite recorded causes.
- R6: Bits 31:6 read back as zero, and writing them has no effect.
- R7: If a cause pulse and a write arrive in the same cycle, the pulsed bit ends up set even when the written value for that bit is 0.
- R8: If an external pulse and other cause pulses arrive in the same cycle, the record holds bit 0 plus exactly those other pulsed bits.
- R9: A read strobe that hits the register raises `bus_rvalid` for exactly the next cycle. The `bus_rdata` returned is the record as it stood before the update at the strobe's clock edge.
- R10: While `por_n` is low, the record is zero and no read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Active-low power-up initialiser, asynchronous |
| cause_pulse | input | 6 | One-cycle reset-source pulses, bit map per R2 |
| bus_addr | input | 6 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid |

## Verification
The assertions check the merge rules on every cycle:
- an external pulse leaves exactly bit 0 plus the other pulsed bits;
- without an external pulse or a write, no recorded bit is lost;
- a pulsed bit is always set after the clock edge.

They also check that the read response follows a hitting strobe by exactly one cycle, with zeros in the reserved bits. Only the bench scenarios can show the values that software sees. These include accumulation over several resets, a write that overwrites the record, a write and a pulse colliding in the same cycle, and accesses to other addresses that leave the record untouched.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
    localparam int CAUSE_W = 6;

    // Bit positions of the cause field
    localparam int C_EXT = 0;
    localparam int C_POR = 1;
    localparam int C_BOR = 2;
    localparam int C_WDT = 3;
    localparam int C_SWR = 4;
    localparam int C_PGL = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_t;
endpackage

// File: rtl/rstcause_capture.sv
module rstcause_capture
    import rstcause_pkg::*;
#(
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [CW-1:0] evt,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] cause
);
    logic [CW-1:0] cause_q;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;

    // A write replaces the held value before the events merge in.
    assign base = wr_en ? wr_val : cause_q;

    // An external event discards the base; events always set their own bit.
    for (genvar i = 0; i < CW; i++) begin : g_merge
        assign nxt[i] = evt[i] | (~evt[C_EXT] & base[i]);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= '0;
        else        cause_q <= nxt;
    end

    assign cause = cause_q;

    // R3 / R8: an external event leaves bit 0 plus exactly the co-pulsed bits
    assert_ext_replaces_R3: assert property (@(posedge clk) disable iff (!por_n)
        evt[C_EXT] |=> (cause == $past(evt)));

    // R4: without an external event or a write, no recorded bit is lost
    assert_accumulate_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!evt[C_EXT] && !wr_en) |=> ((cause & $past(cause)) == $past(cause)));

    // R7: a pulsed bit is set after the edge, whatever was written
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!por_n)
        (|evt) |=> ((cause & $past(evt)) == $past(evt)));

    // R5: a write with no event loads the written value
    assert_write_loads_R5: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && evt == '0) |=> (cause == $past(wr_val)));
endmodule

// File: rtl/rstcause_port.sv
module rstcause_port
    import rstcause_pkg::*;
#(
    parameter int                DW       = 32,
    parameter int                AW       = 6,
    parameter int                CW       = CAUSE_W,
    parameter logic [AW-1:0]     REG_WORD = AW'(23)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic [CW-1:0] cause,
    output logic          wr_en,
    output logic [CW-1:0] wr_val,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int RSV_W = DW - CW;

    port_state_t   state_q, state_d;
    logic          hit;
    logic          rd_hit;
    logic [DW-1:0] rdata_q;

    assign hit    = (addr == REG_WORD);
    assign rd_hit = rd & hit;
    assign wr_en  = wr & hit;
    assign wr_val = wdata[CW-1:0];   // reserved write bits dropped here

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_hit ? ST_RESP : ST_IDLE;   // IDLE_TO_RESP / IDLE_HOLD
            ST_RESP: state_d = rd_hit ? ST_RESP : ST_IDLE;   // RESP_HOLD / RESP_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) rdata_q <= {{RSV_W{1'b0}}, cause};
        end
    end

    always_comb begin
        rvalid = (state_q == ST_RESP);
        rdata  = rdata_q;
    end

    // R9 / R1: a response follows a hitting read strobe, and nothing else
    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!por_n)
        rd_hit |=> rvalid);
    assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!por_n)
        !rd_hit |=> !rvalid);
    // R6: reserved bits always return zero
    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
        rvalid |-> (rdata[DW-1:CW] == '0));
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int            DATA_W   = 32,
    parameter int            ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_WORD = ADDR_W'(23)
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [CAUSE_W-1:0] cause_pulse,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid
);
    logic               wr_en;
    logic [CAUSE_W-1:0] wr_val;
    logic [CAUSE_W-1:0] cause;

    rstcause_capture #(.CW(CAUSE_W)) u_capture (
        .clk    (clk),
        .por_n  (por_n),
        .evt    (cause_pulse),
        .wr_en  (wr_en),
        .wr_val (wr_val),
        .cause  (cause)
    );

    rstcause_port #(
        .DW       (DATA_W),
        .AW       (ADDR_W),
        .CW       (CAUSE_W),
        .REG_WORD (REG_WORD)
    ) u_port (
        .clk    (clk),
        .por_n  (por_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .rd     (bus_rd),
        .cause  (cause),
        .wr_en  (wr_en),
        .wr_val (wr_val),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    // R10: no response while the initialiser holds the block
    always_comb begin
        if (!por_n) assert_idle_in_init_R10: assert (!bus_rvalid);
    end
endmodule

// File: tb/test_rstcause_reg.sv
`timescale 1ns/1ps
module test_rstcause_reg;
    localparam logic [5:0] WORD = 6'h17;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [5:0]  cause_pulse = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic [5:0] model = '0;
    item_t q[$];

    always #10 clk = ~clk;

    rstcause_reg i_rstcause_reg (
        .clk(clk), .por_n(por_n), .cause_pulse(cause_pulse),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    // Driver: one cycle of stimulus; the expected read value goes to the queue
    task automatic step(input logic [5:0] p, input logic wr, input logic [5:0] a,
                        input logic [31:0] wd, input logic rd, input string tag);
        logic [5:0] base;
        @(negedge clk);
        cause_pulse = p; bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_rd = rd;
        if (rd && a == WORD) q.push_back('{exp: {26'b0, model}, tag: tag});
        base  = (wr && a == WORD) ? wd[5:0] : model;
        model = p[0] ? p : (base | p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(6'h0, 1'b0, 6'h0, 32'h0, 1'b0, "");
    endtask

    task automatic rd_check(input string tag);
        step(6'h0, 1'b0, WORD, 32'h0, 1'b1, tag);
    endtask

    // Monitor: compares each response against the queue
    always @(negedge clk) begin
        if (por_n && bus_rvalid) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R1 unexpected response: actual rvalid=1 rdata=%08h expected rvalid=0",
                         bus_rdata);
            end else begin
                item_t it;
                it = q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        // R10: record zero and no response during initialisation
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rvalid !== 1'b0) begin
            failures++;
            $display("FAIL R10 actual rvalid=%b expected 0", bus_rvalid);
        end
        @(negedge clk); por_n = 1'b1;
        rd_check("R10 reset value");
        // R2 / R4: accumulation of power-on, brown-out and watchdog
        step(6'h02, 1'b0, 6'h0, 32'h0, 1'b0, ""); rd_check("R2 power-on bit1");
        step(6'h04, 1'b0, 6'h0, 32'h0, 1'b0, "");
        step(6'h08, 1'b0, 6'h0, 32'h0, 1'b0, ""); rd_check("R4 accumulate 0x0E");
        // R3: an external pulse clears the rest
        step(6'h01, 1'b0, 6'h0, 32'h0, 1'b0, ""); rd_check("R3 external clears");
        step(6'h20, 1'b0, 6'h0, 32'h0, 1'b0, ""); rd_check("R4 keeps ext bit 0x21");
        // R8: external together with software
        step(6'h11, 1'b0, 6'h0, 32'h0, 1'b0, ""); rd_check("R8 ext+sw 0x11");
        // R5 / R6: write with reserved bits set
        step(6'h00, 1'b1, WORD, 32'hFFFF_FFEA, 1'b0, ""); rd_check("R6 reserved zero 0x2A");
        step(6'h00, 1'b1, WORD, 32'h0, 1'b0, ""); rd_check("R5 write clears");
        // R7: a written 0 cannot hide a new event
        step(6'h00, 1'b1, WORD, 32'h3F, 1'b0, "");
        step(6'h20, 1'b1, WORD, 32'h0, 1'b0, ""); rd_check("R7 event beats write");
        step(6'h01, 1'b1, WORD, 32'h3E, 1'b0, ""); rd_check("R7 ext beats write");
        // R1: other addresses neither write nor answer
        step(6'h00, 1'b1, 6'h16, 32'h3F, 1'b0, "");
        step(6'h00, 1'b0, 6'h18, 32'h0, 1'b1, "");
        idle(2);
        rd_check("R1 other address no effect");
        // R9: back-to-back reads, and a read returns the value before a same-cycle pulse
        step(6'h08, 1'b0, WORD, 32'h0, 1'b1, "R9 old value on same-cycle pulse");
        rd_check("R9 back-to-back read");
        step(6'h04, 1'b0, 6'h0, 32'h0, 1'b0, "");
        rd_check("R4 watchdog+brownout 0x0D");
        idle(3);
        // All expected responses must have arrived
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing responses: actual pending=%0d expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule